// File: doc/BRIEF.md
# Composite Video Line and Frame Timer

This block generates all horizontal and vertical timing for a progressive composite video frame of 262 lines. It counts clock ticks at a nominal 16 MHz and fixes every interval as a whole number of ticks. No external sync generator is involved. Each line is 945 ticks long and has four parts: a 76-tick sync pulse, a 76-tick back porch that carries the colour burst window, a 720-tick data region and a 73-tick front porch. The frame is laid out in this order: 242 picture lines, 3 blanking lines, 3 vertical sync lines and 14 further blanking lines. The line duration and the 945-tick structure are the same on every line.

A downstream pixel pipeline uses the tick and line counters, the active-data flag and the blanking flag to place pixels. It uses the refill window to reload its line buffer while no pixels are being shown. A level generator uses the composite sync and burst window outputs. On vertical sync lines the sync sense is inverted for the whole line and the burst window stays off. This replaces separate equalising pulses. All interval lengths and line counts are parameters, and the defaults give the figures above.

Top module: `vid_line_frame_timer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the tick and line counters go to 0. The outputs then show tick 0 of line 0, with `frame_start` high.
- R2: `tick_cnt` advances by one per clock from 0 to 944. After 944 it returns to 0, and `line_cnt` advances by one at that same edge. On every other edge `line_cnt` holds its value.
- R3: `line_cnt` runs from 0 to FRAME_LINES-1 (261 by default) and wraps to 0 after the last tick of the last line.
- R4: `frame_start` is high exactly at tick 0 of line 0, and low at every other position.
- R5: On lines that are not vertical sync lines, `csync` is high (sync asserted) for ticks 0 to 75 and low for ticks 76 to 944.
- R6: The vertical sync lines are lines 245 to 247 by default. On these lines `csync` is inverted: it is low for ticks 0 to 75 and high for ticks 76 to 944.
- R7: `burst_en` is high for ticks 76 to 151 on every line except the vertical sync lines. On vertical sync lines it is never high.
- R8: `active` is high only for ticks 152 to 871 of picture lines 0 to 241.
- R9: `blank` is the inverse of `active`. This means it is high for the whole of every non-picture line, so those lines are held at black.
- R10: `refill` is high on picture lines for ticks 0 to 151 and ticks 872 to 944. It is low on all lines from 242 upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, nominally 16 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| csync | output | 1 | Composite sync, high = sync level asserted |
| burst_en | output | 1 | Colour burst window |
| blank | output | 1 | High when the video level must be black |
| active | output | 1 | High during the picture data region |
| refill | output | 1 | Line buffer reload window on picture lines |
| frame_start | output | 1 | High at tick 0 of line 0 |
| tick_cnt | output | 10 | Tick position within the line |
| line_cnt | output | 9 | Line position within the frame |

## Verification
The bench runs with the horizontal timing at its defaults and a shortened vertical layout, so that frame wrap and vertical sync can be reached quickly. It checks the one-tick edges of each window. An off-by-one comparison would move the active region to tick 151 or 872, or make the burst overlap sync. A design that forgot to invert sync on vertical sync lines, or that kept the burst on there, fails the checks on those lines. A mistake in the line-count boundary would let `refill` or `active` leak into the first blanking line, or stop the frame from wrapping to line 0. A full frame is compared against an independent position model on every cycle, and a reset in mid-frame must return the block to tick 0 of line 0.

// File: rtl/vt_pkg.sv
`timescale 1ns/1ps
// Package: default timing figures shared by the timer and its submodules.
// Assumes a 16 MHz tick; all values are counts of ticks or lines.
package vt_pkg;
    localparam int DEF_SYNC_TICKS   = 76;
    localparam int DEF_BPORCH_TICKS = 76;
    localparam int DEF_ACTIVE_TICKS = 720;
    localparam int DEF_FPORCH_TICKS = 73;
    localparam int DEF_DATA_LINES   = 242;
    localparam int DEF_VBPRE_LINES  = 3;
    localparam int DEF_VSYNC_LINES  = 3;
    localparam int DEF_VBPOST_LINES = 14;
endpackage

// File: rtl/vt_hcount.sv
`timescale 1ns/1ps
// Module: horizontal tick counter.
// Counts 0..LINE_TICKS-1 and flags the last tick of each line.
// Assumes a synchronous active-low reset and one tick per clock.
module vt_hcount #(
    parameter  int LINE_TICKS = 945,
    localparam int TW         = $clog2(LINE_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tick,
    output logic          line_end
);
    localparam logic [TW-1:0] LAST = TW'(LINE_TICKS - 1);

    // Last tick of the line.
    assign line_end = (tick == LAST);

    // Advance the tick count, wrapping at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)        tick <= '0;
        else if (line_end) tick <= '0;
        else               tick <= tick + 1'b1;
    end

    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (tick == '0)); // R2
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> (tick == $past(tick) + 1'b1)); // R2
    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= LAST); // R2
endmodule

// File: rtl/vt_vcount.sv
`timescale 1ns/1ps
// Module: vertical line counter.
// Advances once per line on line_end and wraps after FRAME_LINES-1.
// Assumes line_end is a one-tick pulse from the horizontal counter.
module vt_vcount #(
    parameter  int FRAME_LINES = 262,
    localparam int LW          = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    output logic [LW-1:0] line
);
    localparam logic [LW-1:0] LAST = LW'(FRAME_LINES - 1);

    // Step the line count at each line end, wrapping at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)                      line <= '0;
        else if (line_end && line == LAST) line <= '0;
        else if (line_end)               line <= line + 1'b1;
    end

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && line == LAST) |=> (line == '0)); // R3
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(line)); // R2
    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line <= LAST); // R3
endmodule

// File: rtl/vt_decode.sv
`timescale 1ns/1ps
// Module: window decoder.
// Turns tick and line positions into sync, burst, blank, active and
// refill windows. Pure decode; clk and rst_n only time the assertions.
// Assumes the line is laid out as sync, back porch, data, front porch,
// and the frame as data lines, pre-blank, vsync lines, post-blank.
module vt_decode #(
    parameter int SYNC_TICKS   = 76,
    parameter int BPORCH_TICKS = 76,
    parameter int ACTIVE_TICKS = 720,
    parameter int DATA_LINES   = 242,
    parameter int VBPRE_LINES  = 3,
    parameter int VSYNC_LINES  = 3,
    parameter int TW           = 10,
    parameter int LW           = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tick,
    input  logic [LW-1:0] line,
    output logic          csync,
    output logic          burst_en,
    output logic          blank,
    output logic          active,
    output logic          refill,
    output logic          frame_start
);
    localparam logic [TW-1:0] BURST_BEG = TW'(SYNC_TICKS);
    localparam logic [TW-1:0] DATA_BEG  = TW'(SYNC_TICKS + BPORCH_TICKS);
    localparam logic [TW-1:0] DATA_END  = TW'(SYNC_TICKS + BPORCH_TICKS + ACTIVE_TICKS);
    localparam logic [LW-1:0] PIC_END   = LW'(DATA_LINES);
    localparam logic [LW-1:0] VS_BEG    = LW'(DATA_LINES + VBPRE_LINES);
    localparam logic [LW-1:0] VS_END    = LW'(DATA_LINES + VBPRE_LINES + VSYNC_LINES);

    logic in_sync, in_burst, in_data, pic_line, vs_line;

    // Horizontal region flags.
    always_comb begin
        in_sync  = (tick < BURST_BEG);
        in_burst = (tick >= BURST_BEG) && (tick < DATA_BEG);
        in_data  = (tick >= DATA_BEG) && (tick < DATA_END);
    end

    // Vertical region flags.
    always_comb begin
        pic_line = (line < PIC_END);
        vs_line  = (line >= VS_BEG) && (line < VS_END);
    end

    // Combine regions into the output windows.
    always_comb begin
        csync       = in_sync ^ vs_line;
        burst_en    = in_burst && !vs_line;
        active      = pic_line && in_data;
        blank       = !active;
        refill      = pic_line && !in_data;
        frame_start = (tick == '0) && (line == '0);
    end

    AST_ACT_REFILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && refill)); // R10
    AST_ACTIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (tick == DATA_END)); // R8
    AST_BURST_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_en) |-> $fell(csync)); // R7
endmodule

// File: rtl/vid_line_frame_timer.sv
`timescale 1ns/1ps
// Module: composite video line and frame timer (top).
// Chains the tick counter, the line counter and the window decoder.
// Assumes one clock per tick; outputs are decoded from registered counts.
module vid_line_frame_timer #(
    parameter  int SYNC_TICKS   = vt_pkg::DEF_SYNC_TICKS,
    parameter  int BPORCH_TICKS = vt_pkg::DEF_BPORCH_TICKS,
    parameter  int ACTIVE_TICKS = vt_pkg::DEF_ACTIVE_TICKS,
    parameter  int FPORCH_TICKS = vt_pkg::DEF_FPORCH_TICKS,
    parameter  int DATA_LINES   = vt_pkg::DEF_DATA_LINES,
    parameter  int VBPRE_LINES  = vt_pkg::DEF_VBPRE_LINES,
    parameter  int VSYNC_LINES  = vt_pkg::DEF_VSYNC_LINES,
    parameter  int VBPOST_LINES = vt_pkg::DEF_VBPOST_LINES,
    localparam int LINE_TICKS   = SYNC_TICKS + BPORCH_TICKS + ACTIVE_TICKS + FPORCH_TICKS,
    localparam int FRAME_LINES  = DATA_LINES + VBPRE_LINES + VSYNC_LINES + VBPOST_LINES,
    localparam int TW           = $clog2(LINE_TICKS),
    localparam int LW           = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          csync,
    output logic          burst_en,
    output logic          blank,
    output logic          active,
    output logic          refill,
    output logic          frame_start,
    output logic [TW-1:0] tick_cnt,
    output logic [LW-1:0] line_cnt
);
    logic line_end;

    vt_hcount #(.LINE_TICKS(LINE_TICKS)) u_hcount (
        .clk(clk), .rst_n(rst_n), .tick(tick_cnt), .line_end(line_end)
    );

    vt_vcount #(.FRAME_LINES(FRAME_LINES)) u_vcount (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .line(line_cnt)
    );

    vt_decode #(
        .SYNC_TICKS(SYNC_TICKS), .BPORCH_TICKS(BPORCH_TICKS),
        .ACTIVE_TICKS(ACTIVE_TICKS), .DATA_LINES(DATA_LINES),
        .VBPRE_LINES(VBPRE_LINES), .VSYNC_LINES(VSYNC_LINES),
        .TW(TW), .LW(LW)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .tick(tick_cnt), .line(line_cnt),
        .csync(csync), .burst_en(burst_en), .blank(blank),
        .active(active), .refill(refill), .frame_start(frame_start)
    );

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R4
endmodule

// File: tb/sim_vid_line_frame_timer.sv
`timescale 1ns/1ps
// Bench: default line timing, shortened frame (10 picture lines, 3 pre-blank,
// 3 vsync at lines 13..15, 4 post-blank = 20 lines) to reach frame wrap fast.
module sim_vid_line_frame_timer;
    localparam int LT = 945;
    localparam int DL = 10;
    localparam int VP = 3;
    localparam int VS = 3;
    localparam int VQ = 4;
    localparam int FL = DL + VP + VS + VQ;

    typedef struct packed {
        int         ln;
        int         tk;
        logic [5:0] exp;   // {csync, burst_en, blank, active, refill, frame_start}
        int         req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{0,   0, 6'b101011, 4},  // R4 frame start
        '{0,  75, 6'b101010, 5},  // R5 last sync tick
        '{0,  76, 6'b011010, 7},  // R7 first burst tick
        '{0, 151, 6'b011010, 7},  // R7 last burst tick
        '{0, 152, 6'b000100, 8},  // R8 first active tick
        '{0, 871, 6'b000100, 8},  // R8 last active tick
        '{0, 872, 6'b001010, 10}, // R10 refill after data
        '{0, 944, 6'b001010, 10}, // R10 last tick
        '{9, 500, 6'b000100, 8},  // R8 last picture line
        '{10,  0, 6'b101000, 5},  // R5 blank line sync
        '{10,100, 6'b011000, 7},  // R7 burst on blank line
        '{10,500, 6'b001000, 9},  // R9 blank line held black
        '{13,  0, 6'b001000, 6},  // R6 inverted sync
        '{13,100, 6'b101000, 6},  // R6 burst suppressed
        '{15,944, 6'b101000, 6},  // R6 last vsync tick
        '{16, 50, 6'b101000, 5},  // R5 normal sync again
        '{19,944, 6'b001000, 3}   // R3 last line of frame
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csync, burst_en, blank, active, refill, frame_start;
    logic [9:0] tick_cnt;
    logic [8:0] line_cnt;
    int         cyc = 0;
    int         checks = 0;
    int         failures = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    vid_line_frame_timer #(
        .DATA_LINES(DL), .VBPRE_LINES(VP), .VSYNC_LINES(VS), .VBPOST_LINES(VQ)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .csync(csync), .burst_en(burst_en),
        .blank(blank), .active(active), .refill(refill),
        .frame_start(frame_start), .tick_cnt(tick_cnt), .line_cnt(line_cnt)
    );

    // Bench cycle count since reset release: the position the design should show.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [5:0] model(input int c);
        int t, l;
        logic sy, bu, ac, rf, fs, vs, pic;
        t   = c % LT;
        l   = (c / LT) % FL;
        pic = (l < DL);
        vs  = (l >= DL + VP) && (l < DL + VP + VS);
        sy  = (t < 76) ^ vs;
        bu  = (t >= 76) && (t < 152) && !vs;
        ac  = pic && (t >= 152) && (t < 872);
        rf  = pic && !((t >= 152) && (t < 872));
        fs  = (t == 0) && (l == 0);
        return {sy, bu, !ac, ac, rf, fs};
    endfunction

    function automatic logic [5:0] outs();
        return {csync, burst_en, blank, active, refill, frame_start};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (line %0d tick %0d)",
                     req, act, exp, line_cnt, tick_cnt);
        end
    endtask

    task automatic wait_pos(input int target);
        while (cyc != target) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 counters", {tick_cnt, line_cnt}, 19'd0);
        chk("R1 outputs", outs(), 6'b101011);
        rst_n = 1'b1;

        // Table walk through the first frame.
        for (int i = 0; i < NV; i++) begin
            wait_pos(VEC[i].ln * LT + VEC[i].tk);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), outs(), VEC[i].exp);
            chk("R2 position", {tick_cnt, line_cnt},
                {10'(VEC[i].tk), 9'(VEC[i].ln)});
        end

        // R3: wrap to line 0 after last tick of last line.
        wait_pos(FL * LT);
        chk("R3 wrap", {tick_cnt, line_cnt}, 19'd0);
        chk("R4 frame start on wrap", frame_start, 1'b1);
        @(negedge clk);
        chk("R4 frame start single", frame_start, 1'b0);
        chk("R2 step after wrap", tick_cnt, 10'd1);

        // Full-frame sweep against the position model (R5..R10).
        while (cyc < 2 * FL * LT) begin
            chk("R5 R6 R7 R8 R9 R10 sweep", outs(), model(cyc));
            @(negedge clk);
        end

        // R1: reset in mid-frame.
        wait_pos(2 * FL * LT + 14 * LT + 300);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-frame reset counters", {tick_cnt, line_cnt}, 19'd0);
        chk("R1 mid-frame reset outputs", outs(), 6'b101011);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 count resumes", tick_cnt, 10'd1);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule